// File: doc/BRIEF.md
# Host Bridge Interrupt Aggregator

This block gathers every interrupt source of a host bus bridge and presents them to the system interrupt controller. Four active-low legacy interrupt lines (A to D) come from the bus. Four single-cycle error pulses come from the bus protocol engines: system error, master abort, target abort and parity error. Two single-cycle pulses come from the DMA engine: transfer done and transfer error. Software sees one control word and one status word through a small synchronous register port. The error and DMA events are held in sticky status bits until software clears them by writing ones.

A two-bit routing strap selects how many of the five interrupt outputs are used. At one extreme every source shares output 0. At the other, each legacy line has its own output and DMA events have a dedicated output 4. Every output is level-sensitive, active high and registered. The control word also drives a bus reset output.

Top module: `hbi_irq_top`

## Requirements
- R1: After reset, irq_out is 0, bus_rst is 0, the control word reads 0 and the six sticky bits read 0.
- R2: The control word (word address 0) keeps bits 31, 27, 25 and 3:0 as written. All other bits read as zero. Bit 31 drives bus_rst.
- R3: Control bits 3:0 enable legacy lines A, B, C and D. A pending line (line_n bit low) whose enable bit is clear reaches no output.
- R4: Status (word address 1) bits 11:8 return line_n[3:0] at their raw level, so a pending line reads 0. Bits 25:24 return route_mode, and writes do not change them. Unlisted status bits read as zero.
- R5: A one-cycle pulse sets its sticky status bit: bit 17 system error, 14 master abort, 13 target abort, 12 parity error, 16 DMA done, 15 DMA error.
- R6: Writing 1 to a sticky bit at status clears it. Writing 0 leaves it unchanged. If a pulse and a clearing write for the same bit arrive in one cycle, the bit stays set.
- R7: Master abort, target abort and parity error raise an interrupt only while control bit 25 is set. System error raises one only while control bit 27 is set. A pending DMA sticky bit always raises an interrupt.
- R8: route_mode 0: enabled lines, errors and DMA all drive irq_out[0]. route_mode 1: the same, except DMA drives irq_out[4].
- R9: route_mode 2 and 3: enabled line A drives irq_out[0], B drives [1], C drives [2], D drives [3], and errors drive irq_out[0]. DMA drives irq_out[0] in mode 2 and irq_out[4] in mode 3.
- R10: irq_out is registered. A line change shows on irq_out at the next clock edge. An event pulse shows on irq_out two edges later. Outputs that the mode leaves unused stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address: 0 control, 1 status |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| line_n | input | 4 | Legacy interrupt lines A..D, active low |
| evt_sys | input | 1 | System error pulse |
| evt_mabort | input | 1 | Master abort pulse |
| evt_tabort | input | 1 | Target abort pulse |
| evt_parity | input | 1 | Parity error pulse |
| dma_done | input | 1 | DMA done pulse |
| dma_err | input | 1 | DMA error pulse |
| route_mode | input | 2 | Routing strap |
| bus_rst | output | 1 | Bus reset drive |
| irq_out | output | 5 | Level interrupt outputs |

## Verification
A lost or stuck sticky bit shows in two places. It appears in status bits 17:12 on the read one cycle after the pulse. It also appears on irq_out one edge after that, provided the matching enable is set. A wrong routing decode shows as the wrong irq_out bit one edge after a line changes. Lost enable state shows as an interrupt from a disabled source. The bench checks each source in each mode. It checks that a clearing write removes the interrupt on the next edge, and that a pulse arriving together with the clearing write keeps the bit set.

// File: rtl/hbi_irq_pkg.sv
package hbi_irq_pkg;
  localparam int NUM_LINES = 4;
  localparam int NUM_OUTS  = 5;
  localparam int NUM_EVT   = 6;
  localparam int DMA_OUT   = NUM_OUTS - 1;

  // sticky event indices; status bit = STAT_EVT_LSB + index
  localparam int EV_PAR  = 0;
  localparam int EV_TABT = 1;
  localparam int EV_MABT = 2;
  localparam int EV_DERR = 3;
  localparam int EV_DDON = 4;
  localparam int EV_SYS  = 5;

  localparam int STAT_LINE_LSB = 8;
  localparam int STAT_EVT_LSB  = 12;
  localparam int STAT_MODE_LSB = 24;

  localparam int CTL_ERR_EN = 25;
  localparam int CTL_SYS_EN = 27;
  localparam int CTL_BRST   = 31;

  typedef logic [NUM_EVT-1:0] evt_vec_t;

  typedef struct packed {
    logic                 bus_rst;
    logic                 sys_en;
    logic                 err_en;
    logic [NUM_LINES-1:0] line_en;
  } ctl_t;
endpackage

// File: rtl/hbi_irq_regs.sv
module hbi_irq_regs
  import hbi_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wen,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] line_n,
  input  evt_vec_t             evt_in,
  input  logic [1:0]           route_mode,
  output ctl_t                 ctl_q,
  output evt_vec_t             sticky_q
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

  ctl_t     ctl_d;
  evt_vec_t sticky_d;
  logic     ctl_we;
  logic     stat_we;
  evt_vec_t clr_mask;

  always_comb begin
    ctl_we   = reg_wen && (reg_addr == A_CTL);
    stat_we  = reg_wen && (reg_addr == A_STAT);
    clr_mask = stat_we ? reg_wdata[STAT_EVT_LSB +: NUM_EVT] : '0;
    // a new pulse wins over a clearing write
    sticky_d = (sticky_q & ~clr_mask) | evt_in;
    ctl_d    = ctl_q;
    if (ctl_we) begin
      ctl_d.bus_rst = reg_wdata[CTL_BRST];
      ctl_d.sys_en  = reg_wdata[CTL_SYS_EN];
      ctl_d.err_en  = reg_wdata[CTL_ERR_EN];
      ctl_d.line_en = reg_wdata[NUM_LINES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      sticky_q <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_d;
      sticky_q <= sticky_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTL) begin
      reg_rdata[CTL_BRST]        = ctl_q.bus_rst;
      reg_rdata[CTL_SYS_EN]      = ctl_q.sys_en;
      reg_rdata[CTL_ERR_EN]      = ctl_q.err_en;
      reg_rdata[NUM_LINES-1:0]   = ctl_q.line_en;
    end else if (reg_addr == A_STAT) begin
      reg_rdata[STAT_MODE_LSB +: 2]         = route_mode;
      reg_rdata[STAT_EVT_LSB +: NUM_EVT]    = sticky_q;
      reg_rdata[STAT_LINE_LSB +: NUM_LINES] = line_n;
    end
  end
endmodule

// File: rtl/hbi_irq_route.sv
module hbi_irq_route
  import hbi_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_n,
  input  ctl_t                 ctl_q,
  input  evt_vec_t             sticky_q,
  input  logic [1:0]           route_mode,
  output logic [NUM_OUTS-1:0]  irq_q
);
  logic [NUM_LINES-1:0] line_act;
  logic                 err_req;
  logic                 dma_req;
  logic [NUM_OUTS-1:0]  irq_d;

  always_comb begin
    line_act = ~line_n & ctl_q.line_en;
    err_req  = (ctl_q.err_en & (sticky_q[EV_PAR] | sticky_q[EV_TABT] |
                                sticky_q[EV_MABT])) |
               (ctl_q.sys_en & sticky_q[EV_SYS]);
    dma_req  = sticky_q[EV_DDON] | sticky_q[EV_DERR];
    irq_d    = '0;
    if (route_mode[1]) begin
      irq_d[NUM_LINES-1:0] = line_act;
      irq_d[0]             = line_act[0] | err_req;
    end else begin
      irq_d[0] = (|line_act) | err_req;
    end
    if (route_mode[0]) irq_d[DMA_OUT] = dma_req;
    else               irq_d[0]       = irq_d[0] | dma_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/hbi_irq_top.sv
module hbi_irq_top
  import hbi_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [3:0]        line_n,
  input  logic              evt_sys,
  input  logic              evt_mabort,
  input  logic              evt_tabort,
  input  logic              evt_parity,
  input  logic              dma_done,
  input  logic              dma_err,
  input  logic [1:0]        route_mode,
  output logic              bus_rst,
  output logic [4:0]        irq_out
);
  ctl_t     ctl_q;
  evt_vec_t sticky_q;
  evt_vec_t evt_in;

  always_comb begin
    evt_in          = '0;
    evt_in[EV_PAR]  = evt_parity;
    evt_in[EV_TABT] = evt_tabort;
    evt_in[EV_MABT] = evt_mabort;
    evt_in[EV_DERR] = dma_err;
    evt_in[EV_DDON] = dma_done;
    evt_in[EV_SYS]  = evt_sys;
  end

  hbi_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_n(line_n),
    .evt_in(evt_in), .route_mode(route_mode), .ctl_q(ctl_q),
    .sticky_q(sticky_q)
  );

  hbi_irq_route u_route (
    .clk(clk), .rst_n(rst_n), .line_n(line_n), .ctl_q(ctl_q),
    .sticky_q(sticky_q), .route_mode(route_mode), .irq_q(irq_out)
  );

  assign bus_rst = ctl_q.bus_rst;
endmodule

// File: rtl/hbi_irq_chk.sv
module hbi_irq_chk
  import hbi_irq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] line_n,
  input logic       reg_wen,
  input logic [3:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic       evt_mabort,
  input logic       dma_done,
  input logic [1:0] route_mode,
  input ctl_t       ctl_q,
  input evt_vec_t   sticky_q,
  input logic       bus_rst,
  input logic [4:0] irq_out
);
  assert_line_b_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.line_en[1] |=> !irq_out[1]);

  assert_mabort_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mabort |=> sticky_q[EV_MABT]);

  assert_dma_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> sticky_q[EV_DDON]);

  assert_brst_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == 4'd0) |=> (bus_rst == $past(reg_wdata[CTL_BRST])));

  assert_shared_unused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (route_mode[1] == 1'b0) |=> (irq_out[3:1] == 3'b000));

  assert_dma_out_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (route_mode[0] == 1'b0) |=> !irq_out[4]);
endmodule

bind hbi_irq_top hbi_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_n(line_n), .reg_wen(reg_wen),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .evt_mabort(evt_mabort),
  .dma_done(dma_done), .route_mode(route_mode), .ctl_q(ctl_q),
  .sticky_q(sticky_q), .bus_rst(bus_rst), .irq_out(irq_out)
);

// File: tb/tb_hbi_irq_top.sv
module tb_hbi_irq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {mode[1:0], line_en[3:0], line_n[3:0], expected irq[4:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {2'd0, 4'hF, 4'hE, 5'b00001},
    {2'd0, 4'hE, 4'hE, 5'b00000},
    {2'd2, 4'hF, 4'h5, 5'b01010},
    {2'd3, 4'hF, 4'h0, 5'b01111},
    {2'd1, 4'h8, 4'h7, 5'b00001},
    {2'd2, 4'h0, 4'h0, 5'b00000},
    {2'd3, 4'h4, 4'hB, 5'b00100},
    {2'd1, 4'hF, 4'hF, 5'b00000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wen;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  line_n;
  logic        evt_sys, evt_mabort, evt_tabort, evt_parity, dma_done, dma_err;
  logic [1:0]  route_mode;
  logic        bus_rst;
  logic [4:0]  irq_out;
  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbi_irq_top dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_n(line_n),
    .evt_sys(evt_sys), .evt_mabort(evt_mabort), .evt_tabort(evt_tabort),
    .evt_parity(evt_parity), .dma_done(dma_done), .dma_err(dma_err),
    .route_mode(route_mode), .bus_rst(bus_rst), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wen = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // one-cycle pulse on a selected event: 0 sys,1 mab,2 tab,3 par,4 done,5 derr
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evt_sys = 1'b1;
      1: evt_mabort = 1'b1;
      2: evt_tabort = 1'b1;
      3: evt_parity = 1'b1;
      4: dma_done = 1'b1;
      default: dma_err = 1'b1;
    endcase
    @(negedge clk);
    {evt_sys, evt_mabort, evt_tabort, evt_parity, dma_done, dma_err} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wen = 1'b0; reg_wdata = '0;
    line_n = 4'hF; route_mode = 2'd0;
    {evt_sys, evt_mabort, evt_tabort, evt_parity, dma_done, dma_err} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, rv); check("R1 ctrl", rv, 32'h0);
    rd(4'd1, rv); check("R1 sticky", {26'd0, rv[17:12]}, 32'h0);
    check("R1 irq", {27'd0, irq_out}, 32'h0);
    check("R1 bus_rst", {31'd0, bus_rst}, 32'h0);

    // R2 control readback and bus reset
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, rv); check("R2 ctrl mask", rv, 32'h8A00_000F);
    check("R2 bus_rst high", {31'd0, bus_rst}, 32'h1);
    wr(4'd0, 32'h0);
    check("R2 bus_rst low", {31'd0, bus_rst}, 32'h0);

    // R3 R8 R9 R10 vector table for line routing
    for (int i = 0; i < NVEC; i++) begin
      route_mode = VEC[i][14:13];
      wr(4'd0, {28'd0, VEC[i][12:9]});
      @(negedge clk); line_n = VEC[i][8:5];
      settle();
      check($sformatf("R3/R8/R9 vec%0d", i), {27'd0, irq_out}, {27'd0, VEC[i][4:0]});
    end
    line_n = 4'hF; wr(4'd0, 32'h0);

    // R10 line latency: change at negedge, visible after one edge
    route_mode = 2'd2; wr(4'd0, 32'h2);
    @(negedge clk); line_n = 4'hD;
    check("R10 before edge", {27'd0, irq_out}, 32'h0);
    @(negedge clk);
    check("R10 one edge", {27'd0, irq_out}, 32'h2);
    line_n = 4'hF;

    // R4 status line levels and mode, write has no effect on mode
    route_mode = 2'd3; line_n = 4'h6;
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, rv); check("R4 lines+mode", rv, 32'h0300_0600);
    line_n = 4'hF;

    // R5 R7 master abort gated by error enable
    route_mode = 2'd0; wr(4'd0, 32'h0);
    pulse(1);
    rd(4'd1, rv); check("R5 mabort sticky", {26'd0, rv[17:12]}, 32'h04);
    settle(); check("R7 err disabled", {27'd0, irq_out}, 32'h0);
    wr(4'd0, 32'h0200_0000); settle();
    check("R7 err enabled", {27'd0, irq_out}, 32'h1);
    // R6 write zero keeps, write one clears
    wr(4'd1, 32'h0);
    rd(4'd1, rv); check("R6 write0 keeps", {26'd0, rv[17:12]}, 32'h04);
    wr(4'd1, 32'h0000_4000); settle();
    rd(4'd1, rv); check("R6 cleared", {26'd0, rv[17:12]}, 32'h0);
    check("R6 irq drops", {27'd0, irq_out}, 32'h0);

    // R7 system error needs bit 27, not bit 25
    route_mode = 2'd2; pulse(0); settle();
    check("R7 sys gated", {27'd0, irq_out}, 32'h0);
    wr(4'd0, 32'h0800_0000); settle();
    check("R7 sys on line A out", {27'd0, irq_out}, 32'h1);
    wr(4'd1, 32'h0002_0000); wr(4'd0, 32'h0);

    // R5 target abort and parity bits
    pulse(2); pulse(3);
    rd(4'd1, rv); check("R5 tabort+parity", {26'd0, rv[17:12]}, 32'h03);
    wr(4'd1, 32'h0000_3000);

    // R8 R9 DMA routing per mode
    for (int m = 0; m < 4; m++) begin
      route_mode = m[1:0];
      pulse(m == 2 ? 5 : 4); settle();
      check($sformatf("R8/R9 dma mode%0d", m), {27'd0, irq_out},
            (m[0] ? 32'h10 : 32'h01));
      wr(4'd1, 32'h0001_8000); settle();
    end

    // R6 pulse and clearing write in the same cycle: bit stays
    pulse(4);
    @(negedge clk);
    reg_addr = 4'd1; reg_wen = 1'b1; reg_wdata = 32'h0001_0000; dma_done = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; dma_done = 1'b0;
    rd(4'd1, rv); check("R6 set wins", {26'd0, rv[17:12]}, 32'h10);
    wr(4'd1, 32'h0001_0000);
    rd(4'd1, rv); check("R6 final clear", {26'd0, rv[17:12]}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule